// File: doc/BRIEF.md
# Byte-Serial Packet NIC Register Block

This block is a small memory-mapped network interface. A host moves whole frames through it one byte at a time. On the receive side, an inbound byte stream loads one frame into a local buffer. The host then learns the frame length from a count register and pops the bytes one per read from a data register. On the transmit side, the host writes the frame length and then writes the bytes one per access. When the last byte arrives, the block streams the finished frame out on a valid/last/ready port. A single level-sensitive interrupt line is high while any completion or test flag is set.

The register port takes single-cycle read and write strobes and produces combinational read data. It raises a stall output while a transmit frame is streaming, and the host holds its strobe until the stall drops.

The receive path is a state machine with three states: RX_IDLE, RX_FILL and RX_SKIP.
- RX_IDLE goes to RX_FILL when the first byte of a frame is accepted.
- RX_IDLE goes to RX_SKIP when the first byte of a frame is refused.
- RX_FILL returns to RX_IDLE on the last byte.
- RX_FILL goes to RX_SKIP when the frame grows too long, or when a self-test reset arrives in the middle of a frame.
- RX_SKIP returns to RX_IDLE on the last byte of the frame.

The transmit path has two states, TX_LOAD and TX_SEND.
- TX_LOAD goes to TX_SEND on the data write that completes the frame.
- TX_SEND returns to TX_LOAD on the accepted last byte.

Top module: `nic_byte_port`

## Requirements
- R1: Only address bits [5:0] are decoded, so an address of 0x40 plus an offset aliases to that offset.
- R2: Offsets 0x00 and 0x04 read the identifier words 0x42595445 and 0x4E494331. Offset 0x18 (interrupt number), offset 0x20 (TX data) and every undecoded offset read zero.
- R3: The interrupt control register at 0x14 holds bit 0 (TX done), bit 1 (RX done) and bit 31 (test). The irq output is high exactly while any of these bits is set.
- R4: A read of 0x14 returns the register value, and the test bit is cleared after that read.
- R5: A write to 0x14 is prioritised. If data bit 0 is set, only TX done is cleared. Otherwise, if bit 1 is set, only RX done is cleared. Otherwise, if bit 31 is set, a self-test reset runs and the test bit is then set. A write of zero changes no flag.
- R6: After any write to 0x14, busy (offset 0x08, bit 0) is 1 if any interrupt control bit is still set, and 0 otherwise.
- R7: After a hardware reset or a self-test reset, the RX count, RX read position, TX count and TX write position are all zero. A hardware reset also sets busy to 1 with no interrupt flag set.
- R8: An inbound frame is accepted only if busy is 0 when its first byte arrives. A frame of 1514 bytes or more is dropped, and the RX count and the flags are left unchanged.
- R9: When a frame is accepted, its last byte loads the RX count (offset 0x0C) with the frame length, restarts the read position, sets RX done and sets busy.
- R10: A read of RX data (0x1C) while the RX count is nonzero returns the next stored byte and decrements the count. With a count of zero, it returns 0.
- R11: A write to the TX count (0x10) loads the value if it is at most 1514 and loads 0 otherwise. The write also restarts the TX write position.
- R12: Each write to TX data (0x20) stores the low data byte. When the number of stored bytes equals the TX count or reaches 1514, the block streams that many bytes out with tx_last on the final byte, clears the TX count, and sets TX done and busy.
- R13: Writes to the read-only offsets 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C have no effect.
- R14: reg_stall is high while a TX frame is streaming, and a strobe is not acted on while reg_stall is high. tx_data and tx_last hold steady while tx_valid is high and tx_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address; bits [5:0] are decoded |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid during reg_rd |
| reg_stall | output | 1 | Host must hold its strobe while this is high |
| rx_valid | input | 1 | Inbound byte valid |
| rx_data | input | 8 | Inbound byte |
| rx_last | input | 1 | Marks the final inbound byte of a frame |
| tx_valid | output | 1 | Outbound byte valid |
| tx_data | output | 8 | Outbound byte |
| tx_last | output | 1 | Marks the final outbound byte |
| tx_ready | input | 1 | Sink accepts the outbound byte |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume three things about the inputs:
- reg_rd and reg_wr are never high in the same cycle.
- A strobe is held for as long as reg_stall is high.
- Every inbound frame ends with rx_last.

The bench issues each access through tasks that raise one strobe and keep it up until the stall is low. It sends inbound frames as unbroken byte runs that always end with rx_last. No inbound byte arrives while an interrupt control write is in flight, so the checks on busy and on the flags after such a write never see an RX completion in the same cycle.

// File: rtl/nic_byte_port_pkg.sv
package nic_byte_port_pkg;

    localparam logic [5:0] OFS_IDENT_A = 6'h00;
    localparam logic [5:0] OFS_IDENT_B = 6'h04;
    localparam logic [5:0] OFS_BUSY    = 6'h08;
    localparam logic [5:0] OFS_RX_LEN  = 6'h0C;
    localparam logic [5:0] OFS_TX_LEN  = 6'h10;
    localparam logic [5:0] OFS_IRQ_CTL = 6'h14;
    localparam logic [5:0] OFS_IRQ_NUM = 6'h18;
    localparam logic [5:0] OFS_RX_BYTE = 6'h1C;
    localparam logic [5:0] OFS_TX_BYTE = 6'h20;

    localparam int IC_TX_BIT   = 0;
    localparam int IC_RX_BIT   = 1;
    localparam int IC_TEST_BIT = 31;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_FILL,
        RX_SKIP
    } rx_state_e;

    typedef enum logic {
        TX_LOAD,
        TX_SEND
    } tx_state_e;

    typedef struct packed {
        logic test;
        logic rxd;
        logic txd;
    } irq_flags_t;

endpackage

// File: rtl/nic_rx_path.sv
module nic_rx_path
    import nic_byte_port_pkg::*;
#(
    parameter int MAX_LEN = 1514,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             busy,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic             pop,
    output logic [LEN_W-1:0] cnt,
    output logic [7:0]       rd_byte,
    output logic             commit
);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);

    rx_state_e        st, st_n;
    logic [LEN_W-1:0] idx, rptr;
    logic [7:0]       mem [MAX_LEN-1];
    logic             accept, too_long, wr_en;
    logic [LEN_W-1:0] wr_idx, commit_len;

    always_comb begin
        accept     = in_valid && (st == RX_IDLE) && !busy && (cnt < MAX_L);
        too_long   = (idx == MAX_L - ONE_L);
        wr_en      = 1'b0;
        commit     = 1'b0;
        wr_idx     = idx;
        commit_len = idx + ONE_L;
        st_n       = st;
        unique case (st)
            RX_IDLE: begin
                wr_idx     = '0;
                commit_len = ONE_L;
                wr_en      = accept && !soft_rst;
                commit     = accept && in_last && !soft_rst;
                if (in_valid && !in_last)
                    st_n = (accept && !soft_rst) ? RX_FILL : RX_SKIP;
            end
            RX_FILL: begin
                if (soft_rst) begin
                    st_n = (in_valid && in_last) ? RX_IDLE : RX_SKIP;
                end else if (in_valid) begin
                    wr_en  = !too_long;
                    commit = in_last && !too_long;
                    if (in_last)      st_n = RX_IDLE;
                    else if (too_long) st_n = RX_SKIP;
                end
            end
            RX_SKIP: begin
                if (in_valid && in_last) st_n = RX_IDLE;
            end
            default: st_n = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (wr_en) begin
            idx <= wr_idx + ONE_L;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cnt  <= '0;
            rptr <= '0;
        end else if (commit) begin
            cnt  <= commit_len;
            rptr <= '0;
        end else if (pop && cnt != '0) begin
            cnt  <= cnt - ONE_L;
            rptr <= rptr + ONE_L;
        end
    end

    assign rd_byte = (cnt != '0) ? mem[rptr] : 8'h00;

    a_r10_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && cnt != '0 && !commit && !soft_rst) |=> (cnt == $past(cnt) - ONE_L));

    a_r8_count_below_max: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt < MAX_L));

    a_r9_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (cnt != '0 && rptr == '0));

endmodule

// File: rtl/nic_tx_path.sv
module nic_tx_path
    import nic_byte_port_pkg::*;
#(
    parameter int MAX_LEN = 1514,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             cnt_wr,
    input  logic [31:0]      cnt_val,
    input  logic             dat_wr,
    input  logic [7:0]       dat_byte,
    output logic [LEN_W-1:0] cnt,
    output logic             fire,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    input  logic             out_ready,
    output logic             sending
);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);

    tx_state_e        st, st_n;
    logic [LEN_W-1:0] wptr, sptr, len, np;
    logic [7:0]       mem [MAX_LEN];

    always_comb begin
        np   = wptr + ONE_L;
        fire = (st == TX_LOAD) && dat_wr && ((np == cnt) || (np >= MAX_L));
        st_n = st;
        unique case (st)
            TX_LOAD: if (fire) st_n = TX_SEND;
            TX_SEND: if (out_ready && out_last) st_n = TX_LOAD;
            default: st_n = TX_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= TX_LOAD;
        else        st <= st_n;
    end

    always_ff @(posedge clk) begin
        if ((st == TX_LOAD) && dat_wr) mem[wptr] <= dat_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cnt  <= '0;
            wptr <= '0;
            len  <= '0;
            sptr <= '0;
        end else if (st == TX_LOAD) begin
            if (cnt_wr) begin
                cnt  <= (cnt_val <= 32'(MAX_LEN)) ? cnt_val[LEN_W-1:0] : '0;
                wptr <= '0;
            end else if (fire) begin
                len  <= np;
                cnt  <= '0;
                wptr <= '0;
                sptr <= '0;
            end else if (dat_wr) begin
                wptr <= np;
            end
        end else if (out_ready) begin
            sptr <= sptr + ONE_L;
        end
    end

    always_comb begin
        sending   = (st == TX_SEND);
        out_valid = sending;
        out_data  = sending ? mem[sptr] : 8'h00;
        out_last  = sending && (sptr == len - ONE_L);
    end

    a_r14_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    a_r12_fire_starts_stream: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (out_valid && cnt == '0));

    a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= MAX_L));

endmodule

// File: rtl/nic_byte_port.sv
module nic_byte_port
    import nic_byte_port_pkg::*;
#(
    parameter int          ADDR_W  = 12,
    parameter int          MAX_LEN = 1514,
    parameter logic [31:0] IDENT_A = 32'h4259_5445,
    parameter logic [31:0] IDENT_B = 32'h4E49_4331
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_stall,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              irq
);
    localparam int LEN_W = $clog2(MAX_LEN + 1);

    logic [5:0]       off;
    logic             rd_go, wr_go, ic_wr, ic_rd, soft_rst;
    logic             busy, busy_n;
    irq_flags_t       flags, flags_n;
    logic [LEN_W-1:0] rx_cnt, tx_cnt;
    logic [7:0]       rx_byte;
    logic             rx_commit, tx_fire, sending;
    logic             unused_addr_hi;

    assign unused_addr_hi = ^reg_addr[ADDR_W-1:6];
    assign off       = reg_addr[5:0];
    assign reg_stall = sending;
    assign rd_go     = reg_rd && !sending;
    assign wr_go     = reg_wr && !sending;
    assign ic_wr     = wr_go && (off == OFS_IRQ_CTL);
    assign ic_rd     = rd_go && (off == OFS_IRQ_CTL);
    assign soft_rst  = ic_wr && !reg_wdata[IC_TX_BIT] && !reg_wdata[IC_RX_BIT]
                       && reg_wdata[IC_TEST_BIT];

    nic_rx_path #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .busy     (busy),
        .in_valid (rx_valid),
        .in_data  (rx_data),
        .in_last  (rx_last),
        .pop      (rd_go && (off == OFS_RX_BYTE)),
        .cnt      (rx_cnt),
        .rd_byte  (rx_byte),
        .commit   (rx_commit)
    );

    nic_tx_path #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .cnt_wr    (wr_go && (off == OFS_TX_LEN)),
        .cnt_val   (reg_wdata),
        .dat_wr    (wr_go && (off == OFS_TX_BYTE)),
        .dat_byte  (reg_wdata[7:0]),
        .cnt       (tx_cnt),
        .fire      (tx_fire),
        .out_valid (tx_valid),
        .out_data  (tx_data),
        .out_last  (tx_last),
        .out_ready (tx_ready),
        .sending   (sending)
    );

    always_comb begin
        flags_n = flags;
        busy_n  = busy;
        if (ic_rd) flags_n.test = 1'b0;
        if (ic_wr) begin
            if (reg_wdata[IC_TX_BIT])        flags_n.txd = 1'b0;
            else if (reg_wdata[IC_RX_BIT])   flags_n.rxd = 1'b0;
            else if (reg_wdata[IC_TEST_BIT]) flags_n = '{test: 1'b1, rxd: 1'b0, txd: 1'b0};
            busy_n = |flags_n;
        end
        if (tx_fire) begin
            flags_n.txd = 1'b1;
            busy_n      = 1'b1;
        end
        if (rx_commit) begin
            flags_n.rxd = 1'b1;
            busy_n      = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            busy  <= 1'b1;
        end else begin
            flags <= flags_n;
            busy  <= busy_n;
        end
    end

    assign irq = |flags;

    always_comb begin
        reg_rdata = 32'h0;
        if (reg_rd) begin
            unique case (off)
                OFS_IDENT_A: reg_rdata = IDENT_A;
                OFS_IDENT_B: reg_rdata = IDENT_B;
                OFS_BUSY:    reg_rdata = {31'h0, busy};
                OFS_RX_LEN:  reg_rdata = 32'(rx_cnt);
                OFS_TX_LEN:  reg_rdata = 32'(tx_cnt);
                OFS_IRQ_CTL: reg_rdata = {flags.test, 29'h0, flags.rxd, flags.txd};
                OFS_RX_BYTE: reg_rdata = {24'h0, rx_byte};
                default:     reg_rdata = 32'h0;
            endcase
        end
    end

    a_r4_test_cleared_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        ic_rd |=> !flags.test);

    a_r5_tx_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_wr && reg_wdata[IC_TX_BIT]) |=> !flags.txd);

    a_r6_busy_tracks_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_wr && !rx_commit) |=> (busy == (flags != '0)));

    a_r3_irq_after_rx: assert property (@(posedge clk) disable iff (!rst_n)
        rx_commit |=> (irq && busy));

    a_r13_rx_len_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && off == OFS_RX_LEN && !rx_commit) |=> $stable(rx_cnt));

    a_r14_stall_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fire |=> reg_stall);

endmodule

// File: tb/tb_nic_byte_port.sv
module tb_nic_byte_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_stall;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        irq;

    int checks = 0;
    int bad = 0;

    always #4 clk = ~clk;

    nic_byte_port dut (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_stall(reg_stall), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .irq(irq)
    );

    // {op(1=write), addr, wdata, expected read, expected irq after}
    localparam int NV = 33;
    localparam logic [77:0] VEC [NV] = '{
        {1'b0, 12'h000, 32'h0,         32'h4259_5445, 1'b0}, // R2
        {1'b0, 12'h004, 32'h0,         32'h4E49_4331, 1'b0}, // R2
        {1'b0, 12'h008, 32'h0,         32'h1,         1'b0}, // R7
        {1'b0, 12'h00C, 32'h0,         32'h0,         1'b0}, // R7
        {1'b0, 12'h010, 32'h0,         32'h0,         1'b0}, // R7
        {1'b0, 12'h014, 32'h0,         32'h0,         1'b0}, // R3
        {1'b0, 12'h018, 32'h0,         32'h0,         1'b0}, // R2
        {1'b0, 12'h020, 32'h0,         32'h0,         1'b0}, // R2
        {1'b0, 12'h024, 32'h0,         32'h0,         1'b0}, // R2
        {1'b0, 12'h03C, 32'h0,         32'h0,         1'b0}, // R2
        {1'b0, 12'h048, 32'h0,         32'h1,         1'b0}, // R1
        {1'b0, 12'h040, 32'h0,         32'h4259_5445, 1'b0}, // R1
        {1'b1, 12'h014, 32'h0,         32'h0,         1'b0}, // R6
        {1'b0, 12'h008, 32'h0,         32'h0,         1'b0}, // R6
        {1'b1, 12'h00C, 32'h5,         32'h0,         1'b0}, // R13
        {1'b0, 12'h00C, 32'h0,         32'h0,         1'b0}, // R13
        {1'b1, 12'h008, 32'h1,         32'h0,         1'b0}, // R13
        {1'b0, 12'h008, 32'h0,         32'h0,         1'b0}, // R13
        {1'b1, 12'h010, 32'd1515,      32'h0,         1'b0}, // R11
        {1'b0, 12'h010, 32'h0,         32'h0,         1'b0}, // R11
        {1'b1, 12'h010, 32'd1514,      32'h0,         1'b0}, // R11
        {1'b0, 12'h010, 32'h0,         32'd1514,      1'b0}, // R11
        {1'b1, 12'h050, 32'h7,         32'h0,         1'b0}, // R1
        {1'b0, 12'h010, 32'h0,         32'h7,         1'b0}, // R1
        {1'b1, 12'h010, 32'h9,         32'h0,         1'b0}, // R11
        {1'b1, 12'h014, 32'h8000_0000, 32'h0,         1'b1}, // R5 self-test
        {1'b0, 12'h008, 32'h0,         32'h1,         1'b1}, // R6
        {1'b0, 12'h014, 32'h0,         32'h8000_0000, 1'b0}, // R4
        {1'b0, 12'h014, 32'h0,         32'h0,         1'b0}, // R4
        {1'b0, 12'h010, 32'h0,         32'h0,         1'b0}, // R7
        {1'b0, 12'h008, 32'h0,         32'h1,         1'b0}, // R6
        {1'b1, 12'h014, 32'h0,         32'h0,         1'b0}, // R6
        {1'b0, 12'h008, 32'h0,         32'h0,         1'b0}  // R6
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1;
        while (reg_stall) begin @(negedge clk); #1; end
        d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        #1;
        while (reg_stall) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic send_frame(input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = seed + 8'(i); rx_last = (i == n - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain(input string tag, input int len, input logic [7:0] seed);
        int got = 0;
        int cyc = 0;
        while (got < len && cyc < 8000) begin
            @(negedge clk);
            tx_ready = (cyc % 3 != 1);
            #1;
            if (tx_valid && tx_ready) begin
                chk(tag, {24'h0, tx_data}, {24'h0, seed + 8'(got * 7)});
                chk(tag, {31'h0, tx_last}, {31'h0, (got == len - 1)});
                got++;
            end
            cyc++;
            @(posedge clk);
        end
        @(negedge clk);
        tx_ready = 1'b0;
        chk(tag, got, len);
    endtask

    task automatic tx_frame(input int len, input logic [7:0] seed);
        for (int i = 0; i < len; i++)
            bus_wr(12'h020, 32'hABCD_EF00 | 32'(seed + 8'(i * 7)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk("R3 reset irq", {31'h0, irq}, 32'h0);
        chk("R14 reset stall", {31'h0, reg_stall}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][77]) begin
                bus_wr(VEC[k][76:65], VEC[k][64:33]);
            end else begin
                bus_rd(VEC[k][76:65], d);
                chk($sformatf("R1/R2/R4/R6/R7/R11 vec%0d", k), d, VEC[k][32:1]);
            end
            chk($sformatf("R3 irq vec%0d", k), {31'h0, irq}, {31'h0, VEC[k][0]});
        end

        // R9 / R10 basic receive
        send_frame(5, 8'hA0);
        chk("R3 irq after rx", {31'h0, irq}, 32'h1);
        rd_chk("R9 rx len", 12'h00C, 32'd5);
        rd_chk("R9 busy", 12'h008, 32'h1);
        rd_chk("R9 rx done", 12'h014, 32'h2);
        for (int i = 0; i < 5; i++) rd_chk("R10 rx byte", 12'h01C, 32'hA0 + 32'(i));
        rd_chk("R10 rx len empty", 12'h00C, 32'h0);
        rd_chk("R10 empty read", 12'h01C, 32'h0);
        // R8 busy blocks reception
        send_frame(3, 8'h55);
        rd_chk("R8 busy drop", 12'h00C, 32'h0);
        bus_wr(12'h014, 32'h2);
        chk("R3 irq cleared", {31'h0, irq}, 32'h0);
        rd_chk("R6 busy low", 12'h008, 32'h0);

        // R5 priority with both done flags set
        send_frame(2, 8'h10);
        bus_wr(12'h010, 32'd3);
        tx_frame(3, 8'h31);
        chk("R14 stall during send", {31'h0, reg_stall}, 32'h1);
        drain("R12 short frame", 3, 8'h31);
        chk("R14 stall released", {31'h0, reg_stall}, 32'h0);
        rd_chk("R12 tx len cleared", 12'h010, 32'h0);
        rd_chk("R3 both flags", 12'h014, 32'h3);
        bus_wr(12'h014, 32'h3);
        rd_chk("R5 tx cleared first", 12'h014, 32'h2);
        bus_wr(12'h014, 32'h1);
        rd_chk("R5 bit0 wins", 12'h014, 32'h2);
        rd_chk("R6 busy held", 12'h008, 32'h1);
        bus_wr(12'h014, 32'h8000_0002);
        rd_chk("R5 rx cleared", 12'h014, 32'h0);
        rd_chk("R6 busy drop", 12'h008, 32'h0);
        rd_chk("R5 no reset", 12'h00C, 32'h2);
        bus_wr(12'h01C, 32'h0);
        rd_chk("R13 rx data write", 12'h00C, 32'h2);
        rd_chk("R10 byte0", 12'h01C, 32'h10);
        rd_chk("R10 byte1", 12'h01C, 32'h11);
        rd_chk("R10 past end", 12'h01C, 32'h0);

        // R8 length limit
        send_frame(1514, 8'h00);
        rd_chk("R8 oversize dropped", 12'h00C, 32'h0);
        chk("R8 oversize no irq", {31'h0, irq}, 32'h0);
        send_frame(1513, 8'h40);
        rd_chk("R8 max accepted", 12'h00C, 32'd1513);
        rd_chk("R10 first of long", 12'h01C, 32'h40);
        rd_chk("R10 long decrement", 12'h00C, 32'd1512);
        bus_wr(12'h014, 32'h8000_0000);
        rd_chk("R7 soft reset rx len", 12'h00C, 32'h0);
        rd_chk("R4 test bit", 12'h014, 32'h8000_0000);
        bus_wr(12'h014, 32'h0);
        rd_chk("R6 ack", 12'h008, 32'h0);

        // R12 transmit with zero count stops at 1514
        bus_wr(12'h010, 32'h0);
        tx_frame(1514, 8'h05);
        chk("R14 stall long", {31'h0, reg_stall}, 32'h1);
        drain("R12 max frame", 1514, 8'h05);
        rd_chk("R12 tx done", 12'h014, 32'h1);
        rd_chk("R12 busy", 12'h008, 32'h1);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule